// File: doc/BRIEF.md
# Crystal Drift Pulse Compensator

This block derives a one-second tick from a slow crystal strobe and trims the crystal's frequency error by changing how many slow pulses make up one chosen second. Once per correction interval, the second that starts at the interval boundary is made shorter (pulses added) or longer (pulses removed) by an even number of slow pulses. Every other second takes the nominal count.

The host writes an 8-bit adjustment word. Bit 7 picks the interval length. Bit 6 picks the direction. Bits 5:0 hold a magnitude code. A write does not act at once: the value waits in a pending slot, and a busy flag stays high until the next interval boundary moves it into the active slot. A separate enable input stands for the control bit that selects this compensation style. While it is low, every second has the nominal length, but pending values are still transferred at boundaries.

Top module: `drift_pulse_comp`

## Requirements
- R1: With no correction in force, each second lasts exactly PRESCALE `slow_tick` strobes. Cycles without a strobe do not advance the count. `sec_tick` is a single-cycle pulse at the end of each second.
- R2: Bit 7 of the active word sets the interval: 1 means 60 seconds, 0 means 20 seconds. Only the first second after each interval boundary is corrected, and the other seconds of the interval keep the nominal length.
- R3: With bit 6 clear (add) and a code c from 1 to 63 in bits 5:0, the correction is c−1 steps. The corrected second is shortened by two slow pulses per step, so code 1 leaves it unchanged.
- R4: With bit 6 set (subtract) and a nonzero code c, the correction is ((~c) & 63)+1 steps. The corrected second is lengthened by two slow pulses per step.
- R5: A code of 0 gives no correction in either direction.
- R6: The step count is capped at 62 steps (124 pulses). The subtract code 1, which would decode to 63 steps, therefore gives 62.
- R7: A write sets `busy`. At the next interval boundary, the pending word becomes `active_cfg` and `busy` falls in the same cycle that `sec_tick` is high. `active_cfg` changes at no other time.
- R8: A write while `busy` is high replaces the pending word, so only the last value written before the boundary is applied.
- R9: If a write lands in the boundary cycle itself, the earlier pending word becomes active. The new word becomes pending and `busy` stays high until the following boundary.
- R10: While `adj_en` is low, no second is corrected, but the pending word still moves to `active_cfg` at the boundary.
- R11: After reset, `busy` is 0, `active_cfg` is 0 and `sec_tick` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle strobe per slow crystal pulse |
| adj_en | input | 1 | Selects pulse-adjust compensation; low leaves all seconds nominal |
| wr_en | input | 1 | Write strobe for the adjustment word |
| wr_data | input | 8 | Adjustment word: [7] interval, [6] subtract, [5:0] code |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |
| busy | output | 1 | High while a written word waits for the next boundary |
| active_cfg | output | 8 | Adjustment word currently in force |

## Verification
A host write and an interval boundary can fall in the same clock cycle. In that cycle the pending-to-active transfer and the capture of the new pending value both act on the same registers. The bench provokes this by counting nominal seconds from a known boundary and raising `wr_en` on exactly the clock edge that ends the interval. It then judges the outcome at the ports: `sec_tick` must be high, `busy` must still be set, and `active_cfg` must hold the earlier word. The new word must then take effect, with its own corrected second length, at the next boundary.

// File: rtl/drift_pkg.sv
package drift_pkg;
    localparam int CFG_W   = 8;
    localparam int SEL_BIT = 7;
    localparam int DIR_BIT = 6;
    localparam int CODE_W  = 6;

    typedef logic [CFG_W-1:0] cfg_t;
endpackage

// File: rtl/drift_decode.sv
module drift_decode
    import drift_pkg::*;
#(
    parameter int PRESCALE  = 32768,
    parameter int MAX_STEPS = 62,
    parameter int CNT_W     = 16
) (
    input  cfg_t             cfg,
    input  logic             enable,
    output logic [CNT_W-1:0] sec_len
);
    localparam int SW = CODE_W + 1;

    logic [CODE_W-1:0] code;
    logic [SW-1:0]     raw_steps;
    logic [SW-1:0]     steps;
    logic [CNT_W-1:0]  pulses;

    always_comb begin
        code = cfg[CODE_W-1:0];
        // subtract uses a complemented code, add uses code minus one
        if (cfg[DIR_BIT]) begin
            raw_steps = {1'b0, ~code} + SW'(1);
        end else begin
            raw_steps = {1'b0, code} - SW'(1);
        end
        steps = raw_steps;
        if (raw_steps > SW'(MAX_STEPS)) begin
            steps = SW'(MAX_STEPS);
        end
        if (!enable || code == '0) begin
            steps = '0;
        end
        // one step equals two slow pulses
        pulses = CNT_W'({steps, 1'b0});
        if (cfg[DIR_BIT]) begin
            sec_len = CNT_W'(PRESCALE) + pulses;
        end else begin
            sec_len = CNT_W'(PRESCALE) - pulses;
        end
    end
endmodule

// File: rtl/drift_cfg_reg.sv
module drift_cfg_reg
    import drift_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  cfg_t wr_data,
    input  logic boundary,
    output cfg_t active_d,
    output cfg_t active_q,
    output logic busy
);
    typedef struct packed {
        cfg_t pend;
        cfg_t active;
        logic busy;
    } cfg_state_t;

    cfg_state_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        // the boundary moves the old pending word before a new write lands
        if (boundary && r_q.busy) begin
            r_d.active = r_q.pend;
        end
        if (boundary) begin
            r_d.busy = 1'b0;
        end
        if (wr_en) begin
            r_d.pend = wr_data;
            r_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign active_d = r_d.active;
    assign active_q = r_q.active;
    assign busy     = r_q.busy;
endmodule

// File: rtl/drift_prescaler.sv
module drift_prescaler #(
    parameter int PRESCALE   = 32768,
    parameter int SHORT_SECS = 20,
    parameter int LONG_SECS  = 60,
    parameter int CNT_W      = 16,
    parameter int SEC_W      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic             long_sel,
    input  logic [CNT_W-1:0] corr_len,
    output logic             boundary,
    output logic             sec_tick
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] len;
        logic [SEC_W-1:0] sec;
        logic             tick;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic       tick_end;
    logic       last_sec;

    always_comb begin
        s_d      = s_q;
        s_d.tick = 1'b0;
        last_sec = (s_q.sec == (long_sel ? SEC_W'(LONG_SECS - 1) : SEC_W'(SHORT_SECS - 1)));
        tick_end = slow_tick && (s_q.cnt == s_q.len - CNT_W'(1));
        if (tick_end) begin
            s_d.cnt  = '0;
            s_d.tick = 1'b1;
            if (last_sec) begin
                // first second of the new interval carries the correction
                s_d.sec = '0;
                s_d.len = corr_len;
            end else begin
                s_d.sec = s_q.sec + SEC_W'(1);
                s_d.len = CNT_W'(PRESCALE);
            end
        end else if (slow_tick) begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cnt: '0, len: CNT_W'(PRESCALE), sec: '0, tick: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign boundary = tick_end && last_sec;
    assign sec_tick = s_q.tick;
endmodule

// File: rtl/drift_pulse_comp.sv
module drift_pulse_comp
    import drift_pkg::*;
#(
    parameter int PRESCALE   = 32768,
    parameter int SHORT_SECS = 20,
    parameter int LONG_SECS  = 60,
    parameter int MAX_STEPS  = 62
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_tick,
    input  logic       adj_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       sec_tick,
    output logic       busy,
    output logic [7:0] active_cfg
);
    localparam int CNT_W = $clog2(PRESCALE + 2 * MAX_STEPS + 1);
    localparam int SEC_W = $clog2(LONG_SECS);

    logic             boundary;
    cfg_t             act_d;
    cfg_t             act_q;
    logic [CNT_W-1:0] corr_len;

    drift_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .boundary (boundary),
        .active_d (act_d),
        .active_q (act_q),
        .busy     (busy)
    );

    drift_decode #(
        .PRESCALE  (PRESCALE),
        .MAX_STEPS (MAX_STEPS),
        .CNT_W     (CNT_W)
    ) u_dec (
        .cfg     (act_d),
        .enable  (adj_en),
        .sec_len (corr_len)
    );

    drift_prescaler #(
        .PRESCALE   (PRESCALE),
        .SHORT_SECS (SHORT_SECS),
        .LONG_SECS  (LONG_SECS),
        .CNT_W      (CNT_W),
        .SEC_W      (SEC_W)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .long_sel  (act_q[SEL_BIT]),
        .corr_len  (corr_len),
        .boundary  (boundary),
        .sec_tick  (sec_tick)
    );

    assign active_cfg = act_q;
endmodule

// File: rtl/drift_pulse_comp_chk.sv
module drift_pulse_comp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       sec_tick,
    input logic       busy,
    input logic [7:0] active_cfg
);
    assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

    assert_busy_clears_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> sec_tick);

    assert_write_sets_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> busy);

    assert_active_only_at_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |-> $stable(active_cfg));

    assert_idle_keeps_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wr_en) |=> $stable(active_cfg));

    assert_collision_keeps_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && $past(wr_en)) |-> busy);
endmodule

bind drift_pulse_comp drift_pulse_comp_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .sec_tick   (sec_tick),
    .busy       (busy),
    .active_cfg (active_cfg)
);

// File: tb/test_drift_pulse_comp.sv
`timescale 1ns/1ps
module test_drift_pulse_comp;
    localparam int P = 160;

    typedef struct packed {
        logic [7:0]  cfg;
        logic [15:0] len;
        logic [7:0]  secs;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{8'h00, 16'd160, 8'd20},  // R5 zero code, add
        '{8'h05, 16'd152, 8'd20},  // R3 four steps
        '{8'h3F, 16'd36,  8'd20},  // R3 largest add
        '{8'h7E, 16'd164, 8'd20},  // R4 two steps removed
        '{8'h41, 16'd284, 8'd20},  // R6 subtract code 1 capped
        '{8'h42, 16'd284, 8'd20},  // R4 62 steps removed
        '{8'h85, 16'd152, 8'd60},  // R2 long interval
        '{8'hC0, 16'd160, 8'd60},  // R5 zero code, subtract
        '{8'h01, 16'd160, 8'd20}   // R3 code 1 gives zero steps
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_tick = 1'b0;
    logic       adj_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       sec_tick;
    logic       busy;
    logic [7:0] active_cfg;
    logic       gap = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_tick_cyc = 0;

    drift_pulse_comp #(.PRESCALE(P)) i_drift_pulse_comp (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_tick  (slow_tick),
        .adj_en     (adj_en),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .sec_tick   (sec_tick),
        .busy       (busy),
        .active_cfg (active_cfg)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) slow_tick <= gap ? ~slow_tick : 1'b1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_tick(output int per);
        do @(negedge clk); while (!sec_tick);
        per = cyc - last_tick_cyc;
        last_tick_cyc = cyc;
    endtask

    task automatic wait_boundary();
        int p;
        do wait_tick(p); while (busy);
    endtask

    task automatic write_cfg(input logic [7:0] v);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int p;
        int bad;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(sec_tick == 1'b0, "R11", sec_tick, 0);
        check(busy == 1'b0, "R11", busy, 0);
        check(active_cfg == 8'h00, "R11", active_cfg, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            write_cfg(VEC[i].cfg);
            check(busy == 1'b1, "R7", busy, 1);
            wait_boundary();
            check(active_cfg == VEC[i].cfg, "R7", active_cfg, VEC[i].cfg);
            wait_tick(p);
            check(p == int'(VEC[i].len), "R3/R4/R5/R6 corrected second", p, VEC[i].len);
            bad = 0;
            for (int k = 2; k <= int'(VEC[i].secs); k++) begin
                wait_tick(p);
                if (p != P) bad++;
            end
            // R1 and R2: all other seconds of the interval are nominal
            check(bad == 0, "R2", bad, 0);
            wait_tick(p);
            check(p == int'(VEC[i].len), "R2 next boundary", p, VEC[i].len);
        end

        // R8: second write while busy replaces the pending word
        write_cfg(8'h05);
        write_cfg(8'h09);
        check(busy == 1'b1, "R8", busy, 1);
        wait_boundary();
        check(active_cfg == 8'h09, "R8", active_cfg, 8'h09);
        wait_tick(p);
        check(p == 144, "R8", p, 144);

        // R9: write landing in the boundary cycle
        write_cfg(8'h11);
        for (int k = 2; k <= 19; k++) wait_tick(p);
        repeat (P - 1) @(negedge clk);
        write_cfg(8'h21);
        last_tick_cyc = cyc;
        check(sec_tick == 1'b1, "R9 tick", sec_tick, 1);
        check(busy == 1'b1, "R9 busy", busy, 1);
        check(active_cfg == 8'h11, "R9 active", active_cfg, 8'h11);
        wait_tick(p);
        check(p == 128, "R9 old word length", p, 128);
        wait_boundary();
        check(active_cfg == 8'h21, "R9 new word", active_cfg, 8'h21);
        wait_tick(p);
        check(p == 96, "R9 new word length", p, 96);

        // R10: compensation disabled
        adj_en = 1'b0;
        write_cfg(8'h3F);
        wait_boundary();
        check(active_cfg == 8'h3F, "R10 transfer", active_cfg, 8'h3F);
        wait_tick(p);
        check(p == P, "R10 length", p, P);

        // R1: only slow strobes advance the count
        gap = 1'b1;
        wait_tick(p);
        wait_tick(p);
        check(p == 2 * P, "R1 sparse strobes", p, 2 * P);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule